// File: doc/BRIEF.md
# Branch Target and Execution-Space Resolver

This block sits behind instruction decode in a core that can run code either from a small local register memory or from a larger shared main memory. It takes one instruction at a time, together with the current program counter, the current execution-space bit, the Z and C flags and the value of register D. It decides whether a jump or call is taken and which address and execution space come next. For a taken call it also requests a push of the return point. Any instruction that is not a branch passes through and yields the sequential next address.

Instructions enter on a valid/ready stream and results leave on a second valid/ready stream, one result per accepted instruction, in order. The input accepts a new instruction when the output register is empty or is being drained in the same cycle. A result stays frozen on the output while `out_ready` is low. Local space addresses are `LOCAL_AW` bits wide and shared space addresses are `SHARED_AW` bits wide, both counted in 32-bit words. The space bit is 0 for local and 1 for shared.

Top module: `branch_resolve`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. Each accepted instruction gives exactly one result, in order, in the cycle after acceptance. While `out_valid` is 1 and `out_ready` is 0, every output holds its value.
- R3: Bits [31:25] select the format: 7'h7D is the immediate branch, 7'h7F is the register branch, and any other value is not a branch. A non-branch gives `out_taken`=0, `out_push`=0, `out_delayed`=0 and `out_kind`=0. Its `out_pc` is the next address and its `out_mode` is the current space.
- R4: Condition field bits [21:18] form a mask indexed by {Z,C}, and the branch is taken when the bit at that index is 1. 4'hF is always taken and 4'h0 is never taken. An untaken branch gives the next address in the current space.
- R5: The next address is `in_pc`+1, wrapped to the width of the current space.
- R6: Immediate sub-field bits [17:16]=00 jumps to field [15:0] as an absolute address in the same space, truncated to that space's width.
- R7: Sub-field 01 toggles the space and jumps to field [15:0] as an absolute address, truncated to the width of the new space.
- R8: Sub-field 10 jumps to the next address plus the sign-extended 16-bit field, wrapped to the current space width.
- R9: Sub-field 11 toggles the space and treats field [15:0] as absolute, with no offset applied.
- R10: In the register format, selector bits [17:16] give the variant: bit 16 toggles the space and bit 17 marks the branch as delayed. The value on `in_regd` is always an absolute target, truncated to the width of the destination space.
- R11: `out_delayed` reports bit 22 for immediate branches and selector bit 17 for register branches, whether or not the branch is taken. `out_kind` reports bits [24:23] for both formats.
- R12: A taken branch with kind other than 00 is a call: `out_push`=1, `out_ret_pc` is the next address and `out_ret_mode` is the current space.
- R13: Jumps and untaken branches never push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when high with in_valid |
| in_instr | input | 32 | Instruction word |
| in_pc | input | SHARED_AW | Address of this instruction |
| in_mode | input | 1 | Current space, 0 local, 1 shared |
| in_flag_z | input | 1 | Z flag |
| in_flag_c | input | 1 | C flag |
| in_regd | input | 32 | Value of register D |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_taken | output | 1 | Branch taken |
| out_pc | output | SHARED_AW | Next program counter |
| out_mode | output | 1 | Next execution space |
| out_delayed | output | 1 | Delayed-branch flag |
| out_push | output | 1 | Push return point |
| out_ret_pc | output | SHARED_AW | Return address (next sequential) |
| out_ret_mode | output | 1 | Space to restore on return |
| out_kind | output | 2 | Branch kind, 00 jump, others calls |

## Verification
The cycle-by-cycle properties cover the stream rules: the handshake, holding outputs under back-pressure, and the fact that a result follows each acceptance. They also check that never-conditions and non-branch opcodes stay untaken, that always-conditions are taken, that jumps and untaken branches never push, and that a local-space PC never exceeds the local width. The exact target arithmetic can only be shown by the bench's scenarios. That includes relative offsets with wrap at the space boundary, truncation of absolute and register targets, the toggle variants, the flag-mask lookup and the return point of calls.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int INSTR_W  = 32;
  localparam int FIELD_W  = 16;
  localparam int OP_LSB   = 25;
  localparam int KIND_LSB = 23;
  localparam int DLY_BIT  = 22;
  localparam int COND_LSB = 18;
  localparam int SUB_LSB  = 16;

  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_IMM  = 2'd1,
    FMT_REG  = 2'd2
  } br_fmt_e;

  typedef struct packed {
    br_fmt_e              fmt;
    logic [1:0]           kind;
    logic                 delayed;
    logic                 cond_ok;
    logic                 toggle;
    logic                 relative;
    logic [FIELD_W-1:0]   field;
  } br_dec_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
#(
  parameter logic [6:0] IMM_OP = 7'h7D,
  parameter logic [6:0] REG_OP = 7'h7F
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               flag_z,
  input  logic               flag_c,
  output br_dec_t            dec
);
  localparam int NCOMB = 4;

  logic [6:0]       opcode;
  logic [3:0]       cond;
  logic [1:0]       sub;
  logic [NCOMB-1:0] hit;
  logic [1:0]       zc;

  assign opcode = instr[INSTR_W-1:OP_LSB];
  assign cond   = instr[COND_LSB+3:COND_LSB];
  assign sub    = instr[SUB_LSB+1:SUB_LSB];
  assign zc     = {flag_z, flag_c};

  for (genvar g = 0; g < NCOMB; g++) begin : g_cond
    assign hit[g] = cond[g] && (zc == 2'(g));
  end

  always_comb begin
    dec          = '0;
    dec.field    = instr[FIELD_W-1:0];
    dec.cond_ok  = |hit;
    dec.kind     = instr[KIND_LSB+1:KIND_LSB];
    dec.toggle   = sub[0];
    if (opcode == IMM_OP) begin
      dec.fmt      = FMT_IMM;
      dec.delayed  = instr[DLY_BIT];
      dec.relative = sub[1];
    end else if (opcode == REG_OP) begin
      dec.fmt      = FMT_REG;
      dec.delayed  = sub[1];
      dec.relative = 1'b0;
    end else begin
      dec.fmt      = FMT_NONE;
      dec.kind     = 2'b00;
      dec.toggle   = 1'b0;
      dec.relative = 1'b0;
      dec.cond_ok  = 1'b0;
    end
  end
endmodule

// File: rtl/br_target.sv
module br_target
  import br_pkg::*;
#(
  parameter int LOCAL_AW  = 9,
  parameter int SHARED_AW = 16
) (
  input  br_dec_t                dec,
  input  logic [SHARED_AW-1:0]   cur_pc,
  input  logic                   cur_mode,
  input  logic [INSTR_W-1:0]     reg_val,
  output logic [SHARED_AW-1:0]   next_pc,
  output logic [SHARED_AW-1:0]   tgt_pc,
  output logic                   tgt_mode
);
  localparam int WIDE = INSTR_W;
  localparam logic [WIDE-1:0]      ONE_W  = WIDE'(1);
  localparam logic [SHARED_AW-1:0] LMASK  = SHARED_AW'((ONE_W << LOCAL_AW) - ONE_W);
  localparam logic [SHARED_AW-1:0] SMASK  = '1;

  logic [SHARED_AW-1:0] cur_mask;
  logic [SHARED_AW-1:0] dst_mask;
  logic [WIDE-1:0]      seq_w;
  logic [WIDE-1:0]      off_w;
  logic [WIDE-1:0]      rel_w;
  logic [WIDE-1:0]      raw_w;

  assign cur_mask = cur_mode ? SMASK : LMASK;
  assign tgt_mode = cur_mode ^ dec.toggle;
  assign dst_mask = tgt_mode ? SMASK : LMASK;

  assign seq_w   = WIDE'(cur_pc) + ONE_W;
  assign next_pc = seq_w[SHARED_AW-1:0] & cur_mask;

  assign off_w = {{(WIDE-FIELD_W){dec.field[FIELD_W-1]}}, dec.field};
  assign rel_w = WIDE'(next_pc) + off_w;

  always_comb begin
    if (dec.fmt == FMT_REG)
      raw_w = reg_val;
    else if (dec.relative && !dec.toggle)
      raw_w = rel_w;
    else
      raw_w = WIDE'(dec.field);
  end

  assign tgt_pc = raw_w[SHARED_AW-1:0] & dst_mask;
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import br_pkg::*;
#(
  parameter int         LOCAL_AW  = 9,
  parameter int         SHARED_AW = 16,
  parameter logic [6:0] IMM_OP    = 7'h7D,
  parameter logic [6:0] REG_OP    = 7'h7F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [31:0]          in_instr,
  input  logic [SHARED_AW-1:0] in_pc,
  input  logic                 in_mode,
  input  logic                 in_flag_z,
  input  logic                 in_flag_c,
  input  logic [31:0]          in_regd,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_taken,
  output logic [SHARED_AW-1:0] out_pc,
  output logic                 out_mode,
  output logic                 out_delayed,
  output logic                 out_push,
  output logic [SHARED_AW-1:0] out_ret_pc,
  output logic                 out_ret_mode,
  output logic [1:0]           out_kind
);
  br_dec_t              dec;
  logic [SHARED_AW-1:0] seq_pc;
  logic [SHARED_AW-1:0] tgt_pc;
  logic                 tgt_mode;
  logic                 accept;
  logic                 is_branch;
  logic                 take;

  br_decode #(
    .IMM_OP (IMM_OP),
    .REG_OP (REG_OP)
  ) u_dec (
    .instr  (in_instr),
    .flag_z (in_flag_z),
    .flag_c (in_flag_c),
    .dec    (dec)
  );

  br_target #(
    .LOCAL_AW  (LOCAL_AW),
    .SHARED_AW (SHARED_AW)
  ) u_tgt (
    .dec      (dec),
    .cur_pc   (in_pc),
    .cur_mode (in_mode),
    .reg_val  (in_regd),
    .next_pc  (seq_pc),
    .tgt_pc   (tgt_pc),
    .tgt_mode (tgt_mode)
  );

  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign is_branch = (dec.fmt != FMT_NONE);
  assign take      = is_branch && dec.cond_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_taken    <= 1'b0;
      out_pc       <= '0;
      out_mode     <= 1'b0;
      out_delayed  <= 1'b0;
      out_push     <= 1'b0;
      out_ret_pc   <= '0;
      out_ret_mode <= 1'b0;
      out_kind     <= 2'b00;
    end else begin
      if (accept)
        out_valid <= 1'b1;
      else if (out_ready)
        out_valid <= 1'b0;
      if (accept) begin
        out_taken    <= take;
        out_pc       <= take ? tgt_pc : seq_pc;
        out_mode     <= take ? tgt_mode : in_mode;
        out_delayed  <= is_branch && dec.delayed;
        out_push     <= take && (dec.kind != 2'b00);
        out_ret_pc   <= seq_pc;
        out_ret_mode <= in_mode;
        out_kind     <= dec.kind;
      end
    end
  end
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
  parameter int         LOCAL_AW  = 9,
  parameter int         SHARED_AW = 16,
  parameter logic [6:0] IMM_OP    = 7'h7D,
  parameter logic [6:0] REG_OP    = 7'h7F
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [31:0]          in_instr,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 out_taken,
  input logic [SHARED_AW-1:0] out_pc,
  input logic                 out_mode,
  input logic                 out_push,
  input logic [1:0]           out_kind
);
  logic op_branch;
  assign op_branch = (in_instr[31:25] == IMM_OP) || (in_instr[31:25] == REG_OP);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pc) && $stable(out_mode)
                                   && $stable(out_taken) && $stable(out_push)));

  p_nonbranch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !op_branch) |=> (!out_taken && !out_push && out_kind == 2'b00));

  p_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && op_branch && in_instr[21:18] == 4'h0) |=> !out_taken);

  p_always_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && op_branch && in_instr[21:18] == 4'hF) |=> out_taken);

  p_no_push_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (!out_taken || out_kind == 2'b00)) |-> !out_push);

  p_local_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_mode) |-> ((out_pc >> LOCAL_AW) == '0));
endmodule

bind branch_resolve branch_resolve_chk #(
  .LOCAL_AW  (LOCAL_AW),
  .SHARED_AW (SHARED_AW),
  .IMM_OP    (IMM_OP),
  .REG_OP    (REG_OP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_instr  (in_instr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_taken (out_taken),
  .out_pc    (out_pc),
  .out_mode  (out_mode),
  .out_push  (out_push),
  .out_kind  (out_kind)
);

// File: tb/branch_resolve_test.sv
module branch_resolve_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAW = 9;
  localparam int SAW = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [31:0]    in_instr = '0;
  logic [SAW-1:0] in_pc = '0;
  logic           in_mode = 1'b0;
  logic           in_flag_z = 1'b0;
  logic           in_flag_c = 1'b0;
  logic [31:0]    in_regd = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic           out_taken;
  logic [SAW-1:0] out_pc;
  logic           out_mode;
  logic           out_delayed;
  logic           out_push;
  logic [SAW-1:0] out_ret_pc;
  logic           out_ret_mode;
  logic [1:0]     out_kind;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolve #(.LOCAL_AW(LAW), .SHARED_AW(SAW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_pc(in_pc), .in_mode(in_mode),
    .in_flag_z(in_flag_z), .in_flag_c(in_flag_c), .in_regd(in_regd),
    .out_valid(out_valid), .out_ready(out_ready), .out_taken(out_taken),
    .out_pc(out_pc), .out_mode(out_mode), .out_delayed(out_delayed),
    .out_push(out_push), .out_ret_pc(out_ret_pc), .out_ret_mode(out_ret_mode),
    .out_kind(out_kind)
  );

  typedef struct {
    logic [39:0] v;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   stall_mode = 1'b0;
  bit   finished = 1'b0;

  function automatic logic [39:0] pack(logic tk, logic md, logic dl, logic ps,
                                       logic rm, logic [1:0] kd, logic [15:0] pc,
                                       logic [15:0] rp);
    return {tk, md, dl, ps, rm, 1'b0, kd, pc, rp};
  endfunction

  function automatic logic [39:0] model(logic [31:0] ins, logic [15:0] pc, logic md,
                                        logic z, logic c, logic [31:0] rd);
    int lim, nxt, dlim, tgt, off;
    logic isimm, isreg, tk, dl, tog, dm, ps;
    logic [1:0] kd;
    isimm = (ins[31:25] == 7'h7D);
    isreg = (ins[31:25] == 7'h7F);
    lim  = md ? 65536 : 512;
    nxt  = (int'(pc) + 1) % lim;
    tk = 1'b0; dl = 1'b0; kd = 2'b00; ps = 1'b0; dm = md; tgt = nxt;
    if (isimm || isreg) begin
      kd  = ins[24:23];
      tog = ins[16];
      dl  = isreg ? ins[17] : ins[22];
      tk  = ins[18 + int'({z, c})];
      if (tk) begin
        dm   = md ^ tog;
        dlim = dm ? 65536 : 512;
        if (isreg)
          tgt = int'(rd[15:0]) % dlim;
        else if (ins[17] && !tog) begin
          off = int'($signed(ins[15:0]));
          tgt = (((nxt + off) % lim) + lim) % lim;
        end else
          tgt = int'(ins[15:0]) % dlim;
        ps = (kd != 2'b00);
      end
    end
    return pack(tk, dm, dl, ps, md, kd, 16'(tgt), 16'(nxt));
  endfunction

  function automatic logic [31:0] imm(logic [1:0] kd, logic dl, logic [3:0] cd,
                                      logic [1:0] sb, logic [15:0] a);
    return {7'h7D, kd, dl, cd, sb, a};
  endfunction

  function automatic logic [31:0] rgi(logic [1:0] kd, logic [3:0] cd, logic [1:0] sel);
    return {7'h7F, kd, 1'b0, cd, sel, 16'h0};
  endfunction

  task automatic check(bit ok, string tag, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [31:0] ins, logic [15:0] pc, logic md, logic z, logic c,
                      logic [31:0] rd, string tag);
    exp_t e;
    e.v = model(ins, pc, md, z, c, rd);
    e.tag = tag;
    q.push_back(e);
    in_instr = ins; in_pc = pc; in_mode = md; in_flag_z = z; in_flag_c = c;
    in_regd = rd; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // back-pressure pattern
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      out_ready = !stall_mode || (cyc % 3 == 2);
    end
  end

  // monitor: in-order scoreboard and hold check (R2)
  initial begin
    logic [39:0] prev_v = '0;
    bit prev_hold = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        logic [39:0] act;
        act = pack(out_taken, out_mode, out_delayed, out_push, out_ret_mode,
                   out_kind, out_pc, out_ret_pc);
        if (prev_hold)
          check(out_valid && act == prev_v, "R2 hold under back-pressure", act, prev_v);
        if (out_valid && out_ready) begin
          if (q.size() == 0)
            check(1'b0, "R2 unexpected result", act, '0);
          else begin
            exp_t e;
            e = q.pop_front();
            check(act == e.v, e.tag, act, e.v);
          end
        end
        prev_hold = out_valid && !out_ready;
        prev_v = act;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic run_set(string sfx);
    send(32'h0000_1234, 16'h0010, 1'b0, 1'b0, 1'b0, 32'h0, {"R3 non-branch ", sfx});
    send(32'h1234_5678, 16'h01FF, 1'b0, 1'b1, 1'b1, 32'h0, {"R3 R5 non-branch wrap ", sfx});
    send(imm(2'b00, 1'b0, 4'hF, 2'b00, 16'h1234), 16'h0020, 1'b0, 1'b0, 1'b0, 32'h0, {"R6 abs local trunc ", sfx});
    send(imm(2'b00, 1'b0, 4'hF, 2'b01, 16'h1234), 16'h0020, 1'b0, 1'b0, 1'b0, 32'h0, {"R7 abs toggle to shared ", sfx});
    send(imm(2'b00, 1'b0, 4'hF, 2'b01, 16'h1234), 16'h8000, 1'b1, 1'b0, 1'b0, 32'h0, {"R7 abs toggle to local ", sfx});
    send(imm(2'b00, 1'b0, 4'hF, 2'b10, 16'hFFF0), 16'h0100, 1'b1, 1'b0, 1'b0, 32'h0, {"R8 rel shared back ", sfx});
    send(imm(2'b00, 1'b0, 4'hF, 2'b10, 16'h0005), 16'h01FF, 1'b0, 1'b0, 1'b0, 32'h0, {"R8 R5 rel local wrap ", sfx});
    send(imm(2'b00, 1'b0, 4'hF, 2'b10, 16'h0010), 16'hFFFE, 1'b1, 1'b0, 1'b0, 32'h0, {"R8 rel shared wrap ", sfx});
    send(imm(2'b00, 1'b0, 4'hF, 2'b11, 16'h0020), 16'h4000, 1'b1, 1'b0, 1'b0, 32'h0, {"R9 toggle rel is abs ", sfx});
    send(imm(2'b00, 1'b0, 4'h0, 2'b00, 16'h0055), 16'h0030, 1'b0, 1'b1, 1'b1, 32'h0, {"R4 never ", sfx});
    send(imm(2'b00, 1'b0, 4'h4, 2'b00, 16'h0077), 16'h0030, 1'b0, 1'b1, 1'b0, 32'h0, {"R4 mask hit z=1 c=0 ", sfx});
    send(imm(2'b00, 1'b0, 4'h4, 2'b00, 16'h0077), 16'h0030, 1'b0, 1'b0, 1'b1, 32'h0, {"R4 mask miss z=0 c=1 ", sfx});
    send(imm(2'b01, 1'b0, 4'hF, 2'b01, 16'h2000), 16'h0040, 1'b0, 1'b0, 1'b0, 32'h0, {"R12 call toggle push ", sfx});
    send(imm(2'b11, 1'b0, 4'hF, 2'b10, 16'h0004), 16'h0500, 1'b1, 1'b0, 1'b0, 32'h0, {"R12 call rel push ", sfx});
    send(imm(2'b10, 1'b0, 4'h1, 2'b00, 16'h0004), 16'h0050, 1'b0, 1'b1, 1'b1, 32'h0, {"R13 untaken call no push ", sfx});
    send(imm(2'b00, 1'b1, 4'hF, 2'b00, 16'h0009), 16'h0060, 1'b0, 1'b0, 1'b0, 32'h0, {"R11 delayed imm ", sfx});
    send(imm(2'b00, 1'b1, 4'h0, 2'b00, 16'h0009), 16'h0060, 1'b0, 1'b0, 1'b0, 32'h0, {"R11 delayed untaken ", sfx});
    send(rgi(2'b00, 4'hF, 2'b01), 16'h0070, 1'b0, 1'b0, 1'b0, 32'hABCD_1234, {"R10 reg toggle ", sfx});
    send(rgi(2'b00, 4'hF, 2'b11), 16'h0900, 1'b1, 1'b0, 1'b0, 32'h0000_03FF, {"R10 R11 reg delayed toggle ", sfx});
    send(rgi(2'b00, 4'hF, 2'b00), 16'h0900, 1'b1, 1'b0, 1'b0, 32'h0001_BEEF, {"R10 reg plain shared ", sfx});
    send(rgi(2'b01, 4'hF, 2'b10), 16'h0080, 1'b0, 1'b0, 1'b0, 32'h0000_0345, {"R10 R12 reg call ", sfx});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 reset state", {38'b0, out_valid, in_ready}, 40'h1);
    @(posedge clk);
    #1;
    run_set("free");
    stall_mode = 1'b1;
    run_set("stall");
    stall_mode = 1'b0;
    repeat (20) @(posedge clk);
    check(q.size() == 0, "R2 all results delivered", 40'(q.size()), 40'h0);
    finish_run();
  end
endmodule